// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator with External Realignment

This block counts a single high-rate system clock down to two periodic strobes, a frame sync at the 8 kHz rate and a multiframe sync at one quarter of that rate. It also produces a lower-rate companion clock, divided by six from the system clock. A 38.88 MHz system clock therefore gives a 6.48 MHz companion. The three outputs share one reference phase, and an external Sync input can move that phase.

Sync is looked at on sampling edges only. A precision select picks the rate of those edges. When the select is low, every clock edge samples Sync. When it is high, only every other edge samples Sync, which models a 19.44 MHz sampling precision.

A sampled rising edge of Sync restarts the frame and multiframe counters. A mode input decides what happens to the companion divider:
- In dependent mode with companion resync enabled, the companion divider restarts together with the frame counters. All three outputs then share a common edge, and the companion clock may jump in phase.
- In independent mode, or when companion resync is disabled, the companion clock runs on undisturbed.

Top module: `fsdiv_top`

## Requirements
- R1: While rstN is low, frameSync, mfSync and compClk are all 0. At the first rising clock edge after rstN goes high, all three outputs go to 1.
- R2: When no resync occurs, frameSync is high for exactly one clock cycle in every FRAME_LEN cycles.
- R3: mfSync is high together with every MF_RATIO-th frameSync pulse, counting the first pulse after reset or realignment as the first. It is 0 at all other times.
- R4: When no companion reload occurs, compClk has a period of COMP_DIV cycles. It is high for the first COMP_DIV/2 cycles of each period.
- R5: When prec19Sel is 0, every clock edge samples syncIn. When prec19Sel is 1, edges sample syncIn alternately, and the first edge after reset does not sample. A syncIn pulse seen only at a non-sampling edge has no effect.
- R6: A sampled rising edge of syncIn is a sampling edge where syncIn is 1 and the previous sampled value was 0. After such an edge, frameSync and mfSync are high in the following cycle, and the frame count continues from that point.
- R7: Holding syncIn high causes only one realignment. A further realignment needs syncIn to be sampled low and then high.
- R8: When indepMode is 0 and ocnSyncEn is 1, a realignment also restarts the companion divider. compClk is then high for the COMP_DIV/2 cycles after the realigning edge.
- R9: When indepMode is 1 or ocnSyncEn is 0, a realignment leaves the compClk sequence unchanged.
- R10: If a realignment lands on the edge where the frame count would wrap, the multiframe count restarts rather than advancing, so mfSync is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | External realignment input |
| prec19Sel | input | 1 | 1 = sample syncIn on every other edge; 0 = on every edge |
| indepMode | input | 1 | 1 = realign only the frame and multiframe syncs |
| ocnSyncEn | input | 1 | Allows realignment of the companion divider in dependent mode |
| frameSync | output | 1 | One-cycle frame strobe |
| mfSync | output | 1 | One-cycle multiframe strobe |
| compClk | output | 1 | Companion divided clock |

## Verification
Two events can fall on the same clock edge: an external realignment and the natural wrap of the frame counter. In that case the multiframe counter could either advance or restart. The bench provokes this by running a reference count until the frame counter sits in its last cycle. It then raises syncIn so that the sampling edge coincides with the wrap. The result is judged by requiring mfSync to be high in the following cycle. If the counter had advanced instead, mfSync would stay low.

// File: rtl/fsdiv_pkg.sv
package fsdiv_pkg;
  typedef struct packed {
    logic sampEn;
    logic reloadFrame;
    logic reloadComp;
  } fsStrobe_t;
endpackage

// File: rtl/fsdiv_ctrl.sv
module fsdiv_ctrl
  import fsdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncIn,
  input  logic      prec19Sel,
  input  logic      indepMode,
  input  logic      ocnSyncEn,
  output fsStrobe_t strb
);
  logic phase;
  logic syncLast;
  logic sampEn;
  logic syncRise;

  // alternate-edge enable models the half-rate sampling precision
  assign sampEn   = prec19Sel ? phase : 1'b1;
  assign syncRise = sampEn & syncIn & ~syncLast;

  always_comb begin
    strb.sampEn      = sampEn;
    strb.reloadFrame = syncRise;
    strb.reloadComp  = syncRise & ~indepMode & ocnSyncEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      syncLast <= 1'b0;
    end else begin
      phase <= ~phase;
      if (sampEn) syncLast <= syncIn;
    end
  end

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadFrame |=> !strb.reloadFrame); // R7

  AST_SAMP_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    (prec19Sel && strb.sampEn) |=> !(prec19Sel && strb.sampEn)); // R5
endmodule

// File: rtl/fsdiv_dp.sv
module fsdiv_dp
  import fsdiv_pkg::*;
#(
  parameter int FRAME_LEN = 4860,
  parameter int MF_RATIO  = 4,
  parameter int COMP_DIV  = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  fsStrobe_t strb,
  output logic      frameSync,
  output logic      mfSync,
  output logic      compClk
);
  localparam int FW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int MW = (MF_RATIO > 1) ? $clog2(MF_RATIO) : 1;
  localparam int CW = (COMP_DIV > 1) ? $clog2(COMP_DIV) : 1;
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_LEN - 1);
  localparam logic [MW-1:0] MF_LAST    = MW'(MF_RATIO - 1);
  localparam logic [CW-1:0] COMP_LAST  = CW'(COMP_DIV - 1);
  localparam logic [CW-1:0] COMP_HALF  = CW'(COMP_DIV / 2);

  logic [FW-1:0] frameCnt;
  logic [MW-1:0] mfCnt;
  logic [CW-1:0] compCnt;
  logic          frameWrap;

  assign frameWrap = (frameCnt == FRAME_LAST);

  // frame and multiframe counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= FRAME_LAST;
      mfCnt    <= MF_LAST;
    end else if (strb.reloadFrame) begin
      frameCnt <= '0;
      mfCnt    <= '0;
    end else if (frameWrap) begin
      frameCnt <= '0;
      mfCnt    <= (mfCnt == MF_LAST) ? '0 : mfCnt + 1'b1;
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  // companion divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              compCnt <= COMP_LAST;
    else if (strb.reloadComp || compCnt == COMP_LAST) compCnt <= '0;
    else                                    compCnt <= compCnt + 1'b1;
  end

  assign frameSync = (frameCnt == '0);
  assign mfSync    = frameSync && (mfCnt == '0);

  generate
    if (COMP_DIV > 1) begin : g_div
      assign compClk = (compCnt < COMP_HALF);
    end else begin : g_pass
      assign compClk = rstN;
    end
  endgenerate

  AST_RELOAD_ALIGNS: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadFrame |=> (frameSync && mfSync)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !strb.reloadFrame) |=> !frameSync); // R2

  AST_COMP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadComp |=> compClk); // R8
endmodule

// File: rtl/fsdiv_top.sv
module fsdiv_top #(
  parameter int FRAME_LEN = 4860,
  parameter int MF_RATIO  = 4,
  parameter int COMP_DIV  = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic prec19Sel,
  input  logic indepMode,
  input  logic ocnSyncEn,
  output logic frameSync,
  output logic mfSync,
  output logic compClk
);
  fsdiv_pkg::fsStrobe_t strb;

  fsdiv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .prec19Sel (prec19Sel),
    .indepMode (indepMode),
    .ocnSyncEn (ocnSyncEn),
    .strb      (strb)
  );

  fsdiv_dp #(
    .FRAME_LEN (FRAME_LEN),
    .MF_RATIO  (MF_RATIO),
    .COMP_DIV  (COMP_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frameSync (frameSync),
    .mfSync    (mfSync),
    .compClk   (compClk)
  );
endmodule

// File: tb/fsdiv_top_test.sv
module fsdiv_top_test;
  localparam int F = 40;
  localparam int M = 4;
  localparam int C = 6;

  typedef struct packed {
    bit   indep;
    bit   ocn;
    bit   prec;
    byte unsigned gap;
    byte unsigned wid;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b1, 1'b0, 8'd13, 8'd3},
    '{1'b1, 1'b1, 1'b0, 8'd7,  8'd2},
    '{1'b0, 1'b0, 1'b0, 8'd20, 8'd1},
    '{1'b0, 1'b1, 1'b1, 8'd9,  8'd1},
    '{1'b1, 1'b0, 1'b1, 8'd11, 8'd4},
    '{1'b0, 1'b1, 1'b1, 8'd6,  8'd1},
    '{1'b1, 1'b1, 1'b1, 8'd17, 8'd2},
    '{1'b0, 1'b1, 1'b0, 8'd50, 8'd95},
    '{1'b0, 1'b1, 1'b0, 8'd5,  8'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic prec = 1'b0;
  logic indep = 1'b0;
  logic ocn = 1'b0;
  logic frameSync, mfSync, compClk;

  int nChk = 0;
  int nFail = 0;
  int ef = F - 1;
  int em = M - 1;
  int ec = C - 1;
  bit eph = 1'b0;
  bit elast = 1'b0;

  always #4 clk = ~clk;

  fsdiv_top #(.FRAME_LEN(F), .MF_RATIO(M), .COMP_DIV(C)) uut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .prec19Sel(prec),
    .indepMode(indep), .ocnSyncEn(ocn),
    .frameSync(frameSync), .mfSync(mfSync), .compClk(compClk)
  );

  task automatic chk(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference sequence advanced from the requirements, once per edge
  task automatic step();
    bit se, rise;
    @(posedge clk);
    se   = prec ? eph : 1'b1;
    rise = se && syncIn && !elast;
    if (se) elast = syncIn;
    eph = !eph;
    if (rise) begin
      ef = 0;
      em = 0;
      ec = (!indep && ocn) ? 0 : (ec + 1) % C;
    end else begin
      ef = (ef + 1) % F;
      if (ef == 0) em = (em + 1) % M;
      ec = (ec + 1) % C;
    end
    @(negedge clk);
  endtask

  task automatic cmp(string extra);
    chk({"R2 R6 frameSync ", extra}, frameSync, ef == 0);
    chk({"R3 mfSync ", extra}, mfSync, (ef == 0) && (em == 0));
    chk({"R4 R8 R9 compClk ", extra}, compClk, ec < C / 2);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset frameSync", frameSync, 1'b0);
    chk("R1 reset mfSync", mfSync, 1'b0);
    chk("R1 reset compClk", compClk, 1'b0);
    rstN = 1'b1;
    step();
    chk("R1 first frameSync", frameSync, 1'b1);
    chk("R1 first mfSync", mfSync, 1'b1);
    chk("R1 first compClk", compClk, 1'b1);

    for (int v = 0; v < 9; v++) begin
      indep = VEC[v].indep;
      ocn   = VEC[v].ocn;
      prec  = VEC[v].prec;
      for (int g = 0; g < int'(VEC[v].gap); g++) begin
        step();
        cmp("vec gap");
      end
      syncIn = 1'b1;
      for (int w = 0; w < int'(VEC[v].wid); w++) begin
        step();
        cmp("R5 R7 vec sync");
      end
      syncIn = 1'b0;
    end

    // R10: realignment on the wrap edge
    prec = 1'b0; indep = 1'b0; ocn = 1'b1; syncIn = 1'b0;
    step(); cmp("pre R10");
    while (ef != F - 1) begin
      step(); cmp("pre R10");
    end
    syncIn = 1'b1;
    step();
    chk("R10 mfSync restart", mfSync, 1'b1);
    chk("R10 frameSync", frameSync, 1'b1);
    cmp("R10");
    syncIn = 1'b0;
    step(); cmp("post R10");

    // R5: pulse on a non-sampling edge is ignored
    prec = 1'b1;
    while (eph != 1'b0 || ef == F - 1) begin
      step(); cmp("pre R5");
    end
    syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    chk("R5 ignored pulse frameSync", frameSync, 1'b0);
    chk("R5 ignored pulse compClk", compClk, ec < C / 2);
    for (int k = 0; k < 8; k++) begin
      step(); cmp("R5 after ignored pulse");
    end
    // R5: pulse on a sampling edge is taken
    while (eph != 1'b1) begin
      step(); cmp("pre R5");
    end
    syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    chk("R5 sampled pulse frameSync", frameSync, 1'b1);
    chk("R8 sampled pulse compClk", compClk, 1'b1);
    for (int k = 0; k < 2 * F; k++) begin
      step(); cmp("R2 R3 free run");
    end

    // R9: independent mode keeps compClk sequence
    prec = 1'b0; indep = 1'b1; ocn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(); cmp("pre R9");
    end
    syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    chk("R9 indep realign frameSync", frameSync, 1'b1);
    chk("R9 indep compClk", compClk, ec < C / 2);
    for (int k = 0; k < 10; k++) begin
      step(); cmp("R9");
    end

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end
endmodule